// File: doc/BRIEF.md
# Power-Management Event Register Block

This block holds the power-management event state of a chipset function. It keeps a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running power-management timer. Software reaches these through a 64-byte I/O window. The window's base and its enable bit come from configuration registers that sit outside this block. The block combines the enabled events, and one bit of a general-purpose event pair supplied from outside, into a level-sensitive system control interrupt (`sci`).

A separate command port carries the mode-switch codes that firmware writes. One code turns the interrupt-enable bit in the control register on and another turns it off. Any command write can also raise a one-cycle system management interrupt pulse (`smi`) when a configuration gate bit allows it.

The I/O port is valid-only and has no back-pressure. Every request is taken in the cycle `io_valid` is high, because the block has no `ready` output. Each read request returns `io_rvalid` with `io_rdata` exactly one cycle later. Event inputs are level signals sampled on the clock, and each one is acted on at its rising edge.

Top module: `pm_event_regs`

## Requirements
- R1: After reset the status, enable and control registers and the timer all read zero, and `sci` and `smi` are low.
- R2: A request hits the window only when `cfg_io_en` is 1 and `io_addr & 0xFFC0` equals `cfg_io_base[15:0] & 0xFFC0`. A missed read returns 0, and a missed write changes nothing.
- R3: The window offsets are decoded as follows. 0x00 is status, 0x02 is enable and 0x04 is control, and all three are read and written on the low 16 bits. 0x08 is the timer, which is read-only and zero-extended. Every other offset reads 0, and writes to it are ignored.
- R4: Status bits take these positions: timer overflow at bit 0, global lock at bit 5, power button at bit 8 and RTC alarm at bit 10. A rising edge of `ev_glbl`, `ev_pwrbtn` or `ev_rtc` sets the matching bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. When a set and a clear reach the same bit in the same cycle, the set wins.
- R5: The timer counts up by one in every cycle where `tick_en` is high. Status bit 0 sets in the same cycle that the timer's top bit changes value.
- R6: `sci` is high exactly when `status & enable` has any of bits 0, 5, 8 or 10 set, or when `gpe_sts[1] & gpe_en[1]` is 1.
- R7: A write to status or enable is reflected in `sci` directly after the clock edge that performs the write, with no added cycle.
- R8: A command write with code 0xF1 sets control bit 0, and code 0xF0 clears it. Any other code leaves the control register unchanged. A command write takes priority over an I/O write to control in the same cycle.
- R9: `smi` is high for one cycle, in the cycle after each command write made while `cfg_smi_gate` is 1. Otherwise it stays low.
- R10: `cfg_base_rd` returns `cfg_io_base` with bit 0 forced to 1, which marks the base as an I/O-space base.
- R11: `io_rvalid` is high exactly in the cycle after a read request. `io_rdata` then holds the register value as it stood at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_io_base | input | 32 | Configuration dword holding the window base |
| cfg_io_en | input | 1 | Configuration bit enabling window decode |
| cfg_smi_gate | input | 1 | Configuration bit allowing SMI on command writes |
| cfg_base_rd | output | 32 | Read view of the base dword, bit 0 forced to 1 |
| io_valid | input | 1 | I/O request strobe |
| io_write | input | 1 | 1 for write, 0 for read |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 16 | Write data |
| io_rvalid | output | 1 | Read data valid, one cycle after a read request |
| io_rdata | output | 32 | Read data |
| apm_valid | input | 1 | Command port write strobe |
| apm_cmd | input | 8 | Command code |
| tick_en | input | 1 | Timer increment enable |
| ev_rtc | input | 1 | RTC alarm event level |
| ev_pwrbtn | input | 1 | Power button event level |
| ev_glbl | input | 1 | Global lock release event level |
| gpe_sts | input | 8 | General-purpose event status |
| gpe_en | input | 8 | General-purpose event enable |
| sci | output | 1 | Level-sensitive control interrupt |
| smi | output | 1 | One-cycle management interrupt pulse |

## Verification
Most faults in the stored state show up at the ports within one cycle. A wrong status or enable bit changes `sci` at the next compare whenever the matching bit of the other register is set. A missed edge detect, or a clear that wins over a set, leaves `sci` low when it should be high. A timer that counts wrongly is visible on the next read of offset 0x08. A faulty overflow detector stays hidden until the timer's top bit changes, so the bench runs the timer past that point. A wrong decode shows up on the read that follows the write, as a stored value that changed when it should not have.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int REG_W = 16;
  localparam logic [5:0] OFF_STS = 6'h00;
  localparam logic [5:0] OFF_EN  = 6'h02;
  localparam logic [5:0] OFF_CTL = 6'h04;
  localparam logic [5:0] OFF_TMR = 6'h08;
  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));
  localparam logic [7:0] CMD_ON  = 8'hF1;
  localparam logic [7:0] CMD_OFF = 8'hF0;
  localparam logic [15:0] WIN_MASK = 16'hFFC0;
endpackage

// File: rtl/pm_edge_det.sv
module pm_edge_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         msb_flip
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  assign cnt_nxt  = cnt_q + W'(1);
  assign msb_flip = tick & (cnt_nxt[W-1] ^ cnt_q[W-1]);
  assign count    = cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pm_window_dec.sv
module pm_window_dec (
  input  logic [31:0] base,
  input  logic        win_en,
  input  logic [15:0] addr,
  output logic        hit,
  output logic [5:0]  off
);
  import pm_pkg::*;
  assign hit = win_en && ((addr & WIN_MASK) == (base[15:0] & WIN_MASK));
  assign off = addr[5:0];
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_pkg::*;
#(
  parameter int TMR_W   = 24,
  parameter int GPE_W   = 8,
  parameter int GPE_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_io_base,
  input  logic             cfg_io_en,
  input  logic             cfg_smi_gate,
  output logic [31:0]      cfg_base_rd,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [15:0]      io_addr,
  input  logic [15:0]      io_wdata,
  output logic             io_rvalid,
  output logic [31:0]      io_rdata,
  input  logic             apm_valid,
  input  logic [7:0]       apm_cmd,
  input  logic             tick_en,
  input  logic             ev_rtc,
  input  logic             ev_pwrbtn,
  input  logic             ev_glbl,
  input  logic [GPE_W-1:0] gpe_sts,
  input  logic [GPE_W-1:0] gpe_en,
  output logic             sci,
  output logic             smi
);
  localparam int NEV = 3;

  logic [REG_W-1:0] sts_q, en_q, ctl_q;
  logic [REG_W-1:0] sts_set, sts_clr;
  logic [NEV-1:0]   ev_rise;
  logic [TMR_W-1:0] tmr;
  logic             tmr_flip;
  logic             hit;
  logic [5:0]       off;
  logic             wr_hit, rd_req;
  logic [31:0]      rd_mux;

  pm_edge_det #(.N(NEV)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({ev_rtc, ev_pwrbtn, ev_glbl}),
    .rise(ev_rise)
  );

  pm_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .count(tmr), .msb_flip(tmr_flip)
  );

  pm_window_dec u_dec (
    .base(cfg_io_base), .win_en(cfg_io_en), .addr(io_addr),
    .hit(hit), .off(off)
  );

  assign wr_hit = io_valid & io_write & hit;
  assign rd_req = io_valid & ~io_write;

  always_comb begin
    sts_set = '0;
    sts_set[BIT_TMR] = tmr_flip;
    sts_set[BIT_GBL] = ev_rise[0];
    sts_set[BIT_PWR] = ev_rise[1];
    sts_set[BIT_RTC] = ev_rise[2];
    sts_clr = (wr_hit && off == OFF_STS) ? io_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr_hit && off == OFF_EN) en_q <= io_wdata;
      if (apm_valid && apm_cmd == CMD_ON)       ctl_q[0] <= 1'b1;
      else if (apm_valid && apm_cmd == CMD_OFF) ctl_q[0] <= 1'b0;
      else if (!apm_valid && wr_hit && off == OFF_CTL) ctl_q <= io_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (off)
        OFF_STS: rd_mux = {16'h0, sts_q};
        OFF_EN:  rd_mux = {16'h0, en_q};
        OFF_CTL: rd_mux = {16'h0, ctl_q};
        OFF_TMR: rd_mux = 32'(tmr);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
      smi       <= 1'b0;
    end else begin
      io_rvalid <= rd_req;
      if (rd_req) io_rdata <= rd_mux;
      smi <= apm_valid & cfg_smi_gate;
    end
  end

  assign sci = (|(sts_q & en_q & EVT_MASK)) | (gpe_sts[GPE_BIT] & gpe_en[GPE_BIT]);
  assign cfg_base_rd = cfg_io_base | 32'h1;
endmodule

// File: rtl/pm_event_regs_chk.sv
module pm_event_regs_chk
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_io_en,
  input logic             cfg_smi_gate,
  input logic             io_valid,
  input logic             io_write,
  input logic             io_rvalid,
  input logic             apm_valid,
  input logic [7:0]       apm_cmd,
  input logic             tick_en,
  input logic             sci,
  input logic             smi,
  input logic [REG_W-1:0] sts_q,
  input logic [REG_W-1:0] en_q,
  input logic [REG_W-1:0] ctl_q,
  input logic [TMR_W-1:0] tmr
);
  assert_sci_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & en_q & EVT_MASK)) |-> sci);
  assert_cmd_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_valid && apm_cmd == CMD_ON) |=> ctl_q[0]);
  assert_cmd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_valid && apm_cmd == CMD_OFF) |=> !ctl_q[0]);
  assert_smi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(apm_valid && cfg_smi_gate));
  assert_rvalid_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_valid && !io_write));
  assert_closed_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_io_en) |=> $stable(en_q));
  assert_timer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en) |=> $stable(tmr));
endmodule

bind pm_event_regs pm_event_regs_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_io_en(cfg_io_en), .cfg_smi_gate(cfg_smi_gate),
  .io_valid(io_valid), .io_write(io_write), .io_rvalid(io_rvalid),
  .apm_valid(apm_valid), .apm_cmd(apm_cmd), .tick_en(tick_en),
  .sci(sci), .smi(smi), .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q), .tmr(tmr)
);

// File: tb/tb_pm_event_regs.sv
module tb_pm_event_regs;
  localparam int TW = 10;
  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_io_base = 32'h0;
  logic cfg_io_en = 0, cfg_smi_gate = 0;
  logic [31:0] cfg_base_rd;
  logic io_valid = 0, io_write = 0;
  logic [15:0] io_addr = 0, io_wdata = 0;
  logic io_rvalid;
  logic [31:0] io_rdata;
  logic apm_valid = 0;
  logic [7:0] apm_cmd = 0;
  logic tick_en = 0, ev_rtc = 0, ev_pwrbtn = 0, ev_glbl = 0;
  logic [7:0] gpe_sts = 0, gpe_en = 0;
  logic sci, smi;

  int checks = 0, fails = 0, cycles = 0;

  pm_event_regs #(.TMR_W(TW)) dut (.*);

  always #4 clk = ~clk;

  // reference model state
  int m_sts, m_en, m_ctl, m_tmr, m_rdata;
  bit m_rv, m_smi, p_rtc, p_pwr, p_gbl;

  function automatic bit m_hit(int a);
    return cfg_io_en && ((a & 'hFFC0) == (cfg_io_base & 'hFFC0));
  endfunction
  function automatic bit m_sci();
    return ((m_sts & m_en & 'h0521) != 0) || (gpe_sts[1] && gpe_en[1]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_ctl = 0; m_tmr = 0; m_rv = 0; m_smi = 0; m_rdata = 0;
      p_rtc = 0; p_pwr = 0; p_gbl = 0;
    end else begin
      int off, setv, clrv;
      off = io_addr & 'h3F;
      m_rv = io_valid && !io_write;
      if (m_rv) begin
        m_rdata = 0;
        if (m_hit(io_addr)) begin
          if (off == 0) m_rdata = m_sts;
          else if (off == 2) m_rdata = m_en;
          else if (off == 4) m_rdata = m_ctl;
          else if (off == 8) m_rdata = m_tmr;
        end
      end
      setv = 0;
      if (tick_en) begin
        int nt;
        nt = (m_tmr + 1) % (1 << TW);
        if (((nt >> (TW-1)) & 1) != ((m_tmr >> (TW-1)) & 1)) setv |= 1;
        m_tmr = nt;
      end
      if (ev_glbl && !p_gbl) setv |= 'h20;
      if (ev_pwrbtn && !p_pwr) setv |= 'h100;
      if (ev_rtc && !p_rtc) setv |= 'h400;
      p_gbl = ev_glbl; p_pwr = ev_pwrbtn; p_rtc = ev_rtc;
      clrv = (io_valid && io_write && m_hit(io_addr) && off == 0) ? int'(io_wdata) : 0;
      m_sts = (m_sts & ~clrv) | setv;
      if (io_valid && io_write && m_hit(io_addr) && off == 2) m_en = io_wdata;
      if (apm_valid && apm_cmd == 8'hF1) m_ctl |= 1;
      else if (apm_valid && apm_cmd == 8'hF0) m_ctl &= 'hFFFE;
      else if (io_valid && io_write && m_hit(io_addr) && off == 4) m_ctl = io_wdata;
      m_smi = apm_valid && cfg_smi_gate;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(sci == m_sci(), "R6 sci level vs model", int'(sci), int'(m_sci()));
      chk(smi == m_smi, "R9 smi vs model", int'(smi), int'(m_smi));
      chk(io_rvalid == m_rv, "R11 rvalid vs model", int'(io_rvalid), int'(m_rv));
      if (m_rv) chk(io_rdata == m_rdata, "R3 rdata vs model", io_rdata, m_rdata);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); io_valid = 1; io_write = 1; io_addr = 16'(a); io_wdata = 16'(d);
    @(negedge clk); io_valid = 0; io_write = 0;
  endtask
  task automatic rd(int a, int exp, string tag);
    @(negedge clk); io_valid = 1; io_write = 0; io_addr = 16'(a);
    @(negedge clk); io_valid = 0;
    #1 chk(io_rvalid && io_rdata == exp, tag, io_rdata, exp);
  endtask
  task automatic apm(int c);
    @(negedge clk); apm_valid = 1; apm_cmd = 8'(c);
    @(negedge clk); apm_valid = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 50000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    localparam int B = 'h1000;
    idle(3);
    #1 chk(sci == 0 && smi == 0, "R1 outputs low in reset", int'(sci), 0);
    rst_n = 1;
    cfg_io_base = 32'h0000_1025; cfg_io_en = 1;
    #1 chk(cfg_base_rd == 32'h0000_1025, "R10 base readback", cfg_base_rd, 32'h1025);
    cfg_io_base = 32'h0000_1000;
    #1 chk(cfg_base_rd == 32'h0000_1001, "R10 bit0 forced", cfg_base_rd, 32'h1001);
    cfg_io_base = 32'h0000_1025;
    rd(B + 0, 0, "R1 status zero");
    rd(B + 2, 0, "R1 enable zero");
    rd(B + 4, 0, "R1 control zero");
    rd(B + 8, 0, "R1 timer zero");
    // R3 enable readback
    wr(B + 2, 'h0521);
    rd(B + 2, 'h0521, "R3 enable readback");
    // R4 power button edge, W1C
    @(negedge clk); ev_pwrbtn = 1;
    @(negedge clk); #1 chk(sci == 1, "R4 power button sets, R6 sci", int'(sci), 1);
    rd(B + 0, 'h100, "R4 status bit 8");
    wr(B + 0, 'h100);
    #1 chk(sci == 0, "R7 sci drops right after W1C", int'(sci), 0);
    idle(3);
    rd(B + 0, 0, "R4 held level does not re-set");
    ev_pwrbtn = 0;
    // R4 write 0 keeps bits; glbl edge
    @(negedge clk); ev_glbl = 1;
    wr(B + 0, 'h0);
    rd(B + 0, 'h20, "R4 write zero keeps glbl bit");
    // R7 enable masked off
    wr(B + 2, 'h0);
    #1 chk(sci == 0, "R7 sci low after enable cleared", int'(sci), 0);
    wr(B + 2, 'h20);
    #1 chk(sci == 1, "R7 sci high after enable set", int'(sci), 1);
    wr(B + 0, 'h20); ev_glbl = 0;
    // R4 set wins over clear
    @(negedge clk); ev_rtc = 1; io_valid = 1; io_write = 1; io_addr = 16'(B); io_wdata = 16'h400;
    @(negedge clk); io_valid = 0; io_write = 0;
    rd(B + 0, 'h400, "R4 set wins over clear");
    wr(B + 0, 'h400); ev_rtc = 0;
    // R6 gpe
    gpe_sts = 8'h02; gpe_en = 8'h01;
    #1 chk(sci == 0, "R6 gpe unmatched", int'(sci), 0);
    gpe_en = 8'h02;
    #1 chk(sci == 1, "R6 gpe bit 1", int'(sci), 1);
    gpe_sts = 8'h01; gpe_en = 8'h01;
    #1 chk(sci == 0, "R6 gpe bit 0 ignored", int'(sci), 0);
    gpe_sts = 0; gpe_en = 0;
    // R3 unmapped offsets
    wr(B + 6, 'hFFFF);
    wr(B + 8, 'h1234);
    rd(B + 6, 0, "R3 offset 6 reads zero");
    rd(B + 'h0C, 0, "R3 offset C reads zero");
    rd(B + 8, 0, "R3 timer write ignored");
    rd(B + 2, 'h20, "R3 enable untouched by unmapped writes");
    // R2 window
    wr('h2002, 'h0400);
    rd(B + 2, 'h20, "R2 other base write ignored");
    rd('h2002, 0, "R2 other base reads zero");
    cfg_io_en = 0;
    wr(B + 2, 'h0400);
    rd(B + 2, 0, "R2 disabled window reads zero");
    cfg_io_en = 1;
    rd(B + 2, 'h20, "R2 disabled write ignored");
    // R8 / R9 commands
    apm('hF1);
    #1 chk(smi == 0, "R9 no smi without gate", int'(smi), 0);
    rd(B + 4, 1, "R8 enable code");
    apm('h55);
    rd(B + 4, 1, "R8 other code no change");
    cfg_smi_gate = 1;
    @(negedge clk); apm_valid = 1; apm_cmd = 8'hF0;
    @(negedge clk); apm_valid = 0;
    #1 chk(smi == 1, "R9 smi pulse", int'(smi), 1);
    @(negedge clk); #1 chk(smi == 0, "R9 smi one cycle", int'(smi), 0);
    rd(B + 4, 0, "R8 disable code");
    @(negedge clk); apm_valid = 1; apm_cmd = 8'hF1;
    io_valid = 1; io_write = 1; io_addr = 16'(B + 4); io_wdata = 16'h0;
    @(negedge clk); apm_valid = 0; io_valid = 0; io_write = 0;
    rd(B + 4, 1, "R8 command beats I/O write");
    cfg_smi_gate = 0;
    wr(B + 4, 'h0006);
    rd(B + 4, 6, "R3 control write");
    // R5 timer
    wr(B + 2, 'h0001);
    @(negedge clk); tick_en = 1;
    repeat (5) @(negedge clk);
    tick_en = 0;
    rd(B + 8, 5, "R5 timer counts ticks");
    tick_en = 1;
    repeat ((1 << (TW-1)) - 6) @(negedge clk);
    #1 chk(sci == 0, "R5 no overflow before top bit", int'(sci), 0);
    @(negedge clk); tick_en = 0;
    #1 chk(sci == 1, "R5 overflow on top bit change", int'(sci), 1);
    rd(B + 0, 1, "R5 status bit 0");
    rd(B + 8, 1 << (TW-1), "R5 timer at top bit");
    wr(B + 0, 1);
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule